// File: doc/BRIEF.md
# Keyed Watchdog Timer with Pretimeout

This block is a countdown watchdog driven by a one-cycle tick strobe. The strobe is normally derived from a 32.768 kHz time base, so 32768 decrements make one second. Software programs a 32-bit expiry count and a 32-bit early-warning threshold. It writes each value as two 16-bit halves over a simple 16-bit register bus.

When a decrement lands on the threshold, a pending-interrupt flag is set. When a decrement lands on zero with resets allowed, a reset event is latched and a reset request goes out. Every register except the key register is write-protected. Writes reach the other registers only after the key value 0xE551 has been written to the key register. Writing 0x0000 there restores protection.

Writing the low half of the expiry count commits the whole expiry count and the whole threshold into the counter. The same write opens a short busy window measured in ticks. Software can poll that window in the status register. The remaining count can be read back as two halves, and remaining seconds are the count divided by 32768.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the block is write-protected (key register reads 1), the count reads 0, the status register reads 0, and both `irq_o` and `rst_req_o` are low.
- R2: Writing 16'hE551 to the key register (byte address 0x20) lifts protection, so the key register reads 0. Writing 16'h0000 there restores it, so the key register reads 1. Any other value leaves the protection state unchanged.
- R3: While protected, a write to any register other than the key register changes nothing that can be read or observed.
- R4: A write to the expiry-low register (0x00) loads the counter with {expiry-high (0x04), written value} and loads the threshold with {threshold-high (0x30), threshold-low (0x2C)}. The count reads back as its low half at 0x18 and its high half at 0x1C.
- R5: With control bit 1 (count enable) set, the count falls by exactly one in every cycle with `tick` high. It holds when `tick` is low or count enable is clear, and it never goes below zero.
- R6: Status bit 4 (load busy) goes high on every commit and drops after BUSY_TICKS further ticks (default 2), whether or not counting is enabled.
- R7: Status bit 0 (pending interrupt) sets when a decrement brings the count to the threshold value.
- R8: `irq_o` is high exactly when the pending flag is set, control bit 0 (interrupt enable) is set and mask bit 0 at 0x14 is clear.
- R9: A decrement that brings the count to zero while control bit 3 (reset enable) is set latches status bit 3 and raises `rst_req_o`. With reset enable clear, nothing is latched.
- R10: Writing to the clear register (0x0C) with bit 0 set clears the pending flag, and with bit 3 set clears the reset status and `rst_req_o`. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
A write takes effect at the clock edge that samples it. Reads are combinational, so the bench reads the new value in any later cycle. A tick that decrements the count updates the count, the pending flag, the reset status and both outputs at that same edge. The busy bit needs BUSY_TICKS tick edges after the commit edge before it clears. The bench drives every stimulus at the falling edge, waits through the one rising edge that registers it, and reads or samples outputs after the next falling edge. For the set-versus-clear race, the tick and the clear write are driven in the same cycle so that both land on one edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CLR     = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_KEY     = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_PRE_LO  = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_PRE_HI  = 6'h30;

    localparam logic [15:0] UNLOCK_KEY = 16'hE551;

    // status bit positions
    localparam int ST_IRQ  = 0;
    localparam int ST_RST  = 3;
    localparam int ST_BUSY = 4;

    // control word, bit 3 down to bit 0
    typedef struct packed {
        logic rst_en;
        logic mode_new;
        logic cnt_en;
        logic irq_en;
    } ctrl_t;

    // write side effects decoded from the bus
    typedef struct packed {
        logic commit;
        logic clr_irq;
        logic clr_rst;
    } wr_cmd_t;

    function automatic logic [15:0] key_value(input int w);
        return UNLOCK_KEY;
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    output logic                locked,
    output ctrl_t               ctrl,
    output logic                irq_mask,
    output logic [2*HALF_W-1:0] load_q,
    output logic [2*HALF_W-1:0] pre_q,
    output logic [2*HALF_W-1:0] commit_word,
    output wr_cmd_t             cmd
);
    localparam int CNT_W = 2 * HALF_W;

    logic wr_any;
    logic wr_open;
    logic [HALF_W-1:0] key_match;

    assign key_match = HALF_W'(key_value(HALF_W));
    assign wr_any    = bus_sel && bus_wr;
    assign wr_open   = wr_any && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b1;
            ctrl     <= '0;
            irq_mask <= 1'b0;
            load_q   <= '0;
            pre_q    <= '0;
        end else begin
            if (wr_any && bus_addr == OFS_KEY) begin
                if (bus_wdata == key_match) begin
                    locked <= 1'b0;
                end else if (bus_wdata == '0) begin
                    locked <= 1'b1;
                end
            end
            if (wr_open) begin
                case (bus_addr)
                    OFS_LOAD_LO: load_q[HALF_W-1:0]     <= bus_wdata;
                    OFS_LOAD_HI: load_q[CNT_W-1:HALF_W] <= bus_wdata;
                    OFS_PRE_LO:  pre_q[HALF_W-1:0]      <= bus_wdata;
                    OFS_PRE_HI:  pre_q[CNT_W-1:HALF_W]  <= bus_wdata;
                    OFS_CTRL:    ctrl                   <= ctrl_t'(bus_wdata[3:0]);
                    OFS_MASK:    irq_mask               <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cmd         = '0;
        cmd.commit  = wr_open && (bus_addr == OFS_LOAD_LO);
        cmd.clr_irq = wr_open && (bus_addr == OFS_CLR) && bus_wdata[ST_IRQ];
        cmd.clr_rst = wr_open && (bus_addr == OFS_CLR) && bus_wdata[ST_RST];
        commit_word = {load_q[CNT_W-1:HALF_W], bus_wdata};
    end

endmodule

// File: rtl/wdog_down.sv
module wdog_down #(
    parameter int CNT_W      = 32,
    parameter int BUSY_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             commit,
    input  logic [CNT_W-1:0] load_word,
    input  logic [CNT_W-1:0] pre_word,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             hit_pre,
    output logic             hit_zero
);
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] nxt;
    logic             step;

    assign step     = tick && cnt_en && (count != '0) && !commit;
    assign nxt      = count - CNT_W'(1);
    assign hit_pre  = step && (nxt == thr_q);
    assign hit_zero = step && (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            thr_q <= '0;
        end else if (commit) begin
            count <= load_word;
            thr_q <= pre_word;
        end else if (step) begin
            count <= nxt;
        end
    end

    generate
        if (BUSY_TICKS > 0) begin : g_busy
            localparam int BW = $clog2(BUSY_TICKS + 1);
            logic [BW-1:0] busy_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    busy_cnt <= '0;
                end else if (commit) begin
                    busy_cnt <= BW'(BUSY_TICKS);
                end else if (tick && busy_cnt != '0) begin
                    busy_cnt <= busy_cnt - BW'(1);
                end
            end
            assign busy = (busy_cnt != '0);
        end else begin : g_nobusy
            assign busy = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/wdog_events.sv
module wdog_events (
    input  logic clk,
    input  logic rst,
    input  logic hit_pre,
    input  logic hit_zero,
    input  logic irq_en,
    input  logic rst_en,
    input  logic irq_mask,
    input  logic clr_irq,
    input  logic clr_rst,
    output logic irq_flag,
    output logic rst_flag,
    output logic irq_o,
    output logic rst_req_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
            rst_flag <= 1'b0;
        end else begin
            if (hit_pre) begin
                irq_flag <= 1'b1;
            end else if (clr_irq) begin
                irq_flag <= 1'b0;
            end
            if (hit_zero && rst_en) begin
                rst_flag <= 1'b1;
            end else if (clr_rst) begin
                rst_flag <= 1'b0;
            end
        end
    end

    assign irq_o     = irq_flag && irq_en && !irq_mask;
    assign rst_req_o = rst_flag;

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int HALF_W     = 16,
    parameter int BUSY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int CNT_W = 2 * HALF_W;

    logic             locked;
    ctrl_t            ctrl;
    logic             irq_mask;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] commit_word;
    wr_cmd_t          cmd;
    logic [CNT_W-1:0] count;
    logic             busy;
    logic             hit_pre;
    logic             hit_zero;
    logic             irq_flag;
    logic             rst_flag;

    wdog_regfile #(.HALF_W(HALF_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .locked      (locked),
        .ctrl        (ctrl),
        .irq_mask    (irq_mask),
        .load_q      (load_q),
        .pre_q       (pre_q),
        .commit_word (commit_word),
        .cmd         (cmd)
    );

    wdog_down #(.CNT_W(CNT_W), .BUSY_TICKS(BUSY_TICKS)) u_down (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_en    (ctrl.cnt_en),
        .commit    (cmd.commit),
        .load_word (commit_word),
        .pre_word  (pre_q),
        .count     (count),
        .busy      (busy),
        .hit_pre   (hit_pre),
        .hit_zero  (hit_zero)
    );

    wdog_events u_evt (
        .clk       (clk),
        .rst       (rst),
        .hit_pre   (hit_pre),
        .hit_zero  (hit_zero),
        .irq_en    (ctrl.irq_en),
        .rst_en    (ctrl.rst_en),
        .irq_mask  (irq_mask),
        .clr_irq   (cmd.clr_irq),
        .clr_rst   (cmd.clr_rst),
        .irq_flag  (irq_flag),
        .rst_flag  (rst_flag),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_LOAD_LO: bus_rdata = load_q[HALF_W-1:0];
                OFS_LOAD_HI: bus_rdata = load_q[CNT_W-1:HALF_W];
                OFS_PRE_LO:  bus_rdata = pre_q[HALF_W-1:0];
                OFS_PRE_HI:  bus_rdata = pre_q[CNT_W-1:HALF_W];
                OFS_CTRL:    bus_rdata = HALF_W'(ctrl);
                OFS_MASK:    bus_rdata = HALF_W'(irq_mask);
                OFS_CNT_LO:  bus_rdata = count[HALF_W-1:0];
                OFS_CNT_HI:  bus_rdata = count[CNT_W-1:HALF_W];
                OFS_KEY:     bus_rdata = HALF_W'(locked);
                OFS_RAW: begin
                    bus_rdata[ST_IRQ]  = irq_flag;
                    bus_rdata[ST_RST]  = rst_flag;
                    bus_rdata[ST_BUSY] = busy;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int BUSY_TICKS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             locked,
    input ctrl_t            ctrl,
    input logic             commit,
    input logic [CNT_W-1:0] commit_word,
    input logic [CNT_W-1:0] count,
    input logic             busy,
    input logic             irq_flag,
    input logic             irq_o,
    input logic             rst_req_o
);
    // R3: a protected cycle leaves the control word untouched
    p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(ctrl));

    // R4: commit loads the assembled word
    p_commit_load_r4: assert property (@(posedge clk) disable iff (rst)
        commit |=> count == $past(commit_word));

    // R5: no tick, no movement
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!commit && !tick) |=> $stable(count));

    // R5: one step per enabled tick
    p_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (!commit && tick && ctrl.cnt_en && count != '0) |=> count == $past(count) - CNT_W'(1));

    // R5: zero is a floor
    p_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (!commit && count == '0) |=> count == '0);

    // R6: busy follows each commit
    p_commit_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (commit && BUSY_TICKS > 0) |=> busy);

    // R8: interrupt only from an enabled pending flag
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_flag && ctrl.irq_en));

    // R9: reset request only rises with reset enable
    p_rst_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> $past(ctrl.rst_en));

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(2 * HALF_W), .BUSY_TICKS(BUSY_TICKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .locked      (locked),
    .ctrl        (ctrl),
    .commit      (cmd.commit),
    .commit_word (commit_word),
    .count       (count),
    .busy        (busy),
    .irq_flag    (irq_flag),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [5:0] A_LLO = 6'h00, A_LHI = 6'h04, A_CTL = 6'h08, A_CLR = 6'h0C,
                           A_RAW = 6'h10, A_MSK = 6'h14, A_CLO = 6'h18, A_CHI = 6'h1C,
                           A_KEY = 6'h20, A_PLO = 6'h2C, A_PHI = 6'h30;

    always #5 clk = ~clk;

    wdog_keyed i_wdog_keyed (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        logic [15:0] lo, hi;
        rd(A_CLO, lo);
        rd(A_CHI, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load(input logic [31:0] v, input logic [31:0] p);
        wr(A_PHI, p[31:16]);
        wr(A_PLO, p[15:0]);
        wr(A_LHI, v[31:16]);
        wr(A_LLO, v[15:0]);
    endtask

    function automatic logic [31:0] exp_count(input logic [31:0] v, input int n);
        return (v > 32'(n)) ? v - 32'(n) : 32'd0;
    endfunction

    function automatic bit exp_flag(input logic [31:0] v, input logic [31:0] p, input int n);
        return (p < v) && (32'(n) >= v - p);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [31:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_KEY, d); chk("R1 key", 32'(d), 32'd1);
        rd_cnt(c);    chk("R1 count", c, 32'd0);
        rd(A_RAW, d); chk("R1 status", 32'(d), 32'd0);
        chk("R1 outputs", {30'd0, irq_o, rst_req_o}, 32'd0);

        // R3 protected writes ignored
        wr(A_CTL, 16'h000B);
        wr(A_LHI, 16'h0007);
        wr(A_LLO, 16'h0009);
        rd(A_CTL, d); chk("R3 ctrl", 32'(d), 32'd0);
        rd_cnt(c);    chk("R3 count", c, 32'd0);
        rd(A_RAW, d); chk("R3 busy", 32'(d[4]), 32'd0);

        // R2 key handling
        wr(A_KEY, 16'hE551);
        rd(A_KEY, d); chk("R2 unlock", 32'(d), 32'd0);
        wr(A_KEY, 16'h1234);
        rd(A_KEY, d); chk("R2 other value", 32'(d), 32'd0);

        // R4 commit and readback
        wr(A_LHI, 16'h0001);
        wr(A_LLO, 16'h0005);
        rd(A_CLO, d); chk("R4 count lo", 32'(d), 32'h5);
        rd(A_CHI, d); chk("R4 count hi", 32'(d), 32'h1);

        // R6 busy window, R5 no count without enable
        rd(A_RAW, d); chk("R6 busy set", 32'(d[4]), 32'd1);
        ticks(1);
        rd(A_RAW, d); chk("R6 busy after 1", 32'(d[4]), 32'd1);
        ticks(1);
        rd(A_RAW, d); chk("R6 busy after 2", 32'(d[4]), 32'd0);
        rd_cnt(c);    chk("R5 disabled", c, 32'h0001_0005);

        // R5 counting
        wr(A_CTL, 16'h0002);
        ticks(3);
        rd_cnt(c); chk("R5 three ticks", c, 32'h0001_0002);
        repeat (5) @(negedge clk);
        rd_cnt(c); chk("R5 idle hold", c, 32'h0001_0002);

        // R2 relock, R3 ignored
        wr(A_KEY, 16'h0000);
        rd(A_KEY, d); chk("R2 relock", 32'(d), 32'd1);
        wr(A_CTL, 16'h0000);
        wr(A_CLR, 16'h0009);
        rd(A_CTL, d); chk("R3 ctrl kept", 32'(d), 32'd2);
        wr(A_KEY, 16'hE551);

        // R7, R8 pretimeout
        wr(A_MSK, 16'h0000);
        load(32'd6, 32'd3);
        wr(A_CTL, 16'h000B);
        ticks(2);
        rd(A_RAW, d); chk("R7 not yet", 32'(d[0]), 32'd0);
        chk("R8 low before", 32'(irq_o), 32'd0);
        ticks(1);
        rd(A_RAW, d); chk("R7 flag", 32'(d[0]), 32'd1);
        chk("R8 irq", 32'(irq_o), 32'd1);
        wr(A_MSK, 16'h0001);
        chk("R8 masked", 32'(irq_o), 32'd0);
        wr(A_MSK, 16'h0000);
        wr(A_CTL, 16'h000A);
        chk("R8 disabled", 32'(irq_o), 32'd0);
        wr(A_CTL, 16'h000B);
        chk("R8 reenabled", 32'(irq_o), 32'd1);

        // R10 clear pending
        wr(A_CLR, 16'h0001);
        rd(A_RAW, d); chk("R10 irq cleared", 32'(d[0]), 32'd0);
        chk("R10 irq_o low", 32'(irq_o), 32'd0);

        // R9 reset latch, R5 floor
        ticks(3);
        rd_cnt(c);    chk("R9 count zero", c, 32'd0);
        rd(A_RAW, d); chk("R9 status", 32'(d[3]), 32'd1);
        chk("R9 rst_req", 32'(rst_req_o), 32'd1);
        ticks(2);
        rd_cnt(c);    chk("R5 floor", c, 32'd0);
        wr(A_CLR, 16'h0008);
        chk("R10 rst cleared", 32'(rst_req_o), 32'd0);

        // R9 without reset enable
        wr(A_CLR, 16'h0009);
        load(32'd2, 32'd100);
        wr(A_CTL, 16'h0002);
        ticks(2);
        rd_cnt(c);    chk("R9 no enable count", c, 32'd0);
        chk("R9 no enable rst", 32'(rst_req_o), 32'd0);

        // R10 set wins over clear
        load(32'd5, 32'd4);
        wr(A_CTL, 16'h0003);
        @(negedge clk);
        tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 16'h0001;
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_RAW, d); chk("R10 set wins", 32'(d[0]), 32'd1);
        rd_cnt(c);    chk("R10 count", c, 32'd4);

        // randomized loads, R5 R7 R8
        void'($urandom(32'd4321));
        for (int it = 0; it < 24; it++) begin
            logic [31:0] v, p;
            int n;
            bit f;
            v = {15'd0, 1'($urandom % 2), 16'(8 + $urandom % 40)};
            p = 32'($urandom % (v[15:0]));
            n = int'($urandom % (v[15:0] + 4));
            wr(A_CLR, 16'h0009);
            load(v, p);
            ticks(n);
            f = exp_flag(v, p, n);
            rd_cnt(c);    chk("R5 random count", c, exp_count(v, n));
            rd(A_RAW, d); chk("R7 random flag", 32'(d[0]), 32'(f));
            chk("R8 random irq", 32'(irq_o), 32'(f));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule